// File: doc/BRIEF.md
# SDRAM Command Scheduler

This block is the host side of a four-bank synchronous DRAM interface. Coming out of reset it waits out a power-up interval. It then brings the memory up by closing every bank, running two auto-refresh cycles and loading the mode register. The mode register load sets burst length one, sequential ordering and the CAS latency held in a parameter. Once that is done it accepts single-word read and write requests on a valid/ready port.

Each accepted request opens the addressed row. After the row-to-column delay it issues the column command with auto-precharge, then waits out write recovery and precharge before the next command. A down-counter sized from the clock frequency raises a refresh request about every 15.6 µs. A waiting refresh is served ahead of any new user request. Read data from the memory is captured after the programmed CAS latency and returned with a one-cycle valid strobe. Every command, address and data output comes straight from a register, so the memory sees stable values at each rising edge.

Top module: `sdram_sched`

## Requirements
- R1: While reset is held the chip select output is high (deselect). After reset, only NOP (chip select low, other strobes high) appears until the power-up wait ends.
- R2: Bring-up issues these commands in order: precharge with A10 high, auto-refresh, auto-refresh, mode-register load. The gaps are T_RP, T_RFC and T_RFC cycles. The load carries bank 00 and address A2:0=000 (one-word burst), A3=0 (sequential), A6:4=CAS_LAT, all other bits 0.
- R3: `req_ready` is never high before the mode-register load has appeared on the command pins.
- R4: A request taken while `req_valid` and `req_ready` are both high produces, on the next cycle, an activate with `req_bank` on the bank lines and `req_row` on A11:0. The column command follows exactly T_RCD cycles later.
- R5: A write request issues a write command with the column on A(COL_W-1):0 and A10 high. The write data and the drive enable are presented in that same cycle.
- R6: A read request issues a read command with A10 high and the drive enable low. `rd_valid` is high for one cycle, CAS_LAT+1 cycles after the read appears on the pins, and `rd_data` then holds the word the memory drove.
- R7: After a column command, no command follows for T_WR+T_RP cycles. When a request is already waiting, the next activate comes exactly that many cycles later.
- R8: While no requests arrive, an auto-refresh is issued every REF_INT = CLK_MHZ*15625/1000 cycles.
- R9: A due refresh is issued before any waiting request is accepted. It comes no later than REF_INT+T_RCD+T_WR+T_RP cycles after the previous refresh, and the next command follows exactly T_RFC cycles later.
- R10: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as: activate 0011, read 0101, write 0100, precharge 0010, auto-refresh 0001, mode load 0000, NOP 0111, deselect 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change after its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DW | Write word |
| req_ready | output | 1 | Request taken on this edge when valid is high |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | DW | Returned read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select lines |
| sd_a | output | ROW_W | Multiplexed address lines |
| sd_dq_out | output | DW | Write data to memory |
| sd_dq_oe | output | 1 | Data drive enable |
| sd_dq_in | input | DW | Read data from memory |

## Verification
The refresh tick and a user request can become due in the same cycle. The bench provokes this by waiting until a few cycles before the next refresh is due, then holding `req_valid` high across a run of back-to-back writes. The outcome is judged from the command pins. The refresh must land within one request slot of its due time. The following activate must come exactly T_RFC cycles after it. Every queued write must still be issued, and a later read of one of those writes must return its data.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IREF1,
    ST_IREF2,
    ST_IMRS,
    ST_IDLE,
    ST_CAS
  } sched_st_e;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pend
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick, pend_d;

  always_comb begin
    tick = run && (cnt_q == '0);
    if (!run || tick) cnt_d = CW'(INTERVAL - 1);
    else              cnt_d = cnt_q - 1'b1;
    pend_d = tick | (pend & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(INTERVAL - 1);
      pend  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pend  <= pend_d;
    end
  end

  // R9: a due refresh stays pending until the scheduler serves it
  p_pend_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !ack |=> pend);

endmodule

// File: rtl/sdram_rd_return.sv
module sdram_rd_return #(
  parameter int CL = 2,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic [CL:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe_q   <= {pipe_q[CL-1:0], launch};
      rd_valid <= pipe_q[CL];
      if (pipe_q[CL]) rd_data <= dq_in;
    end
  end

  // R6: the strobe trails the read launch by exactly the latency pipeline
  p_rd_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(launch, CL + 2));

endmodule

// File: rtl/sdram_sched.sv
module sdram_sched
  import sdram_sched_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int INIT_CYC = 20000,
  parameter int T_RCD    = 2,
  parameter int T_RP     = 2,
  parameter int T_RFC    = 7,
  parameter int T_MRD    = 2,
  parameter int T_WR     = 2,
  parameter int CAS_LAT  = 2,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 9,
  parameter int DW       = 16,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DW-1:0]     sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DW-1:0]     sd_dq_in
);
  localparam int REF_INT = CLK_MHZ * 15625 / 1000;
  localparam int RW_WAIT = T_WR + T_RP;
  localparam int WMAX    = INIT_CYC + T_RFC + RW_WAIT + T_RCD + T_MRD;
  localparam int WW      = $clog2(WMAX + 1);
  localparam int AP_BIT  = 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  sched_st_e         st_q, st_d;
  logic [WW-1:0]     wcnt_q, wcnt_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d;
  logic [ROW_W-1:0]  a_q, a_d;
  logic [DW-1:0]     dq_q, dq_d;
  logic              oe_q, oe_d;
  logic              lt_we;
  logic [BANK_W-1:0] lt_bank;
  logic [COL_W-1:0]  lt_col;
  logic [DW-1:0]     lt_wdata;
  logic              take, ref_pend, ref_ack, run, rd_launch;

  assign run       = (st_q == ST_IDLE) || (st_q == ST_CAS);
  assign req_ready = (st_q == ST_IDLE) && (wcnt_q == '0) && !ref_pend;
  assign take      = req_ready && req_valid;
  assign rd_launch = (cmd_d == CMD_RD);

  sdram_ref_timer #(.INTERVAL(REF_INT)) u_ref_timer (
    .clk  (clk),
    .rst_n(rst_i_n),
    .run  (run),
    .ack  (ref_ack),
    .pend (ref_pend)
  );

  sdram_rd_return #(.CL(CAS_LAT), .DW(DW)) u_rd_return (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .launch  (rd_launch),
    .dq_in   (sd_dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // next-state and command selection
  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    cmd_d   = CMD_NOP;
    ba_d    = '0;
    a_d     = '0;
    dq_d    = '0;
    oe_d    = 1'b0;
    ref_ack = 1'b0;
    if (wcnt_q != '0) begin
      wcnt_d = wcnt_q - 1'b1;
    end else begin
      case (st_q)
        ST_PWR: begin
          cmd_d       = CMD_PRE;
          a_d[AP_BIT] = 1'b1;
          st_d        = ST_IREF1;
          wcnt_d      = WW'(T_RP - 1);
        end
        ST_IREF1: begin
          cmd_d  = CMD_REF;
          st_d   = ST_IREF2;
          wcnt_d = WW'(T_RFC - 1);
        end
        ST_IREF2: begin
          cmd_d  = CMD_REF;
          st_d   = ST_IMRS;
          wcnt_d = WW'(T_RFC - 1);
        end
        ST_IMRS: begin
          cmd_d  = CMD_MRS;
          a_d    = MODE_WORD;
          st_d   = ST_IDLE;
          wcnt_d = WW'(T_MRD - 1);
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_d   = CMD_REF;
            ref_ack = 1'b1;
            wcnt_d  = WW'(T_RFC - 1);
          end else if (req_valid) begin
            cmd_d  = CMD_ACT;
            ba_d   = req_bank;
            a_d    = req_row;
            st_d   = ST_CAS;
            wcnt_d = WW'(T_RCD - 1);
          end
        end
        ST_CAS: begin
          cmd_d            = lt_we ? CMD_WR : CMD_RD;
          ba_d             = lt_bank;
          a_d[COL_W-1:0]   = lt_col;
          a_d[AP_BIT]      = 1'b1;
          dq_d             = lt_wdata;
          oe_d             = lt_we;
          st_d             = ST_IDLE;
          wcnt_d           = WW'(RW_WAIT - 1);
        end
        default: st_d = ST_PWR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_PWR;
      wcnt_q <= WW'(INIT_CYC - 1);
      cmd_q  <= CMD_DESEL;
      ba_q   <= '0;
      a_q    <= '0;
      dq_q   <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      a_q    <= a_d;
      dq_q   <= dq_d;
      oe_q   <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      lt_we    <= 1'b0;
      lt_bank  <= '0;
      lt_col   <= '0;
      lt_wdata <= '0;
    end else if (take) begin
      lt_we    <= req_write;
      lt_bank  <= req_bank;
      lt_col   <= req_col;
      lt_wdata <= req_wdata;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_a      = a_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;

  // checking state: spacing between commands seen on the pins
  logic [7:0] since_q;
  logic       last_cas_q, mode_set_q, cmd_on, is_cas;
  assign cmd_on = !cmd_q[3] && (cmd_q != CMD_NOP);
  assign is_cas = (cmd_q == CMD_RD) || (cmd_q == CMD_WR);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      since_q    <= '0;
      last_cas_q <= 1'b0;
      mode_set_q <= 1'b0;
    end else begin
      if (cmd_on) begin
        since_q    <= 8'd1;
        last_cas_q <= is_cas;
      end else if (since_q != 8'hFF) begin
        since_q <= since_q + 8'd1;
      end
      if (cmd_q == CMD_MRS) mode_set_q <= 1'b1;
    end
  end

  p_cas_after_act_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    is_cas |-> since_q == 8'(T_RCD));

  p_accept_act_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready && req_valid |=> cmd_q == CMD_ACT);

  p_recovery_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_on && last_cas_q |-> since_q >= 8'(RW_WAIT));

  p_ready_after_mrs_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready |-> (mode_set_q || cmd_q == CMD_MRS));

endmodule

// File: tb/test_sdram_sched.sv
module test_sdram_sched;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ  = 10;
  localparam int INIT_CYC = 40;
  localparam int T_RCD = 2, T_RP = 2, T_RFC = 6, T_MRD = 2, T_WR = 2, CAS_LAT = 2;
  localparam int REF_INT = CLK_MHZ * 15625 / 1000;
  localparam int RW_WAIT = T_WR + T_RP;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [8:0]  req_col;
  logic [15:0] req_wdata;
  logic        req_ready, rd_valid;
  logic [15:0] rd_data;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;
  logic [15:0] sd_dq_out, sd_dq_in;
  logic        sd_dq_oe;

  sdram_sched #(
    .CLK_MHZ(CLK_MHZ), .INIT_CYC(INIT_CYC), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .T_WR(T_WR), .CAS_LAT(CAS_LAT)
  ) i_sdram_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // command log and memory model
  logic [3:0]  lg_cmd[0:255];
  int          lg_cyc[0:255];
  logic [11:0] lg_a[0:255];
  logic [1:0]  lg_ba[0:255];
  logic [15:0] lg_dq[0:255];
  logic        lg_oe[0:255];
  int          n_log = 0, cyc = 0;
  int          rdv_n = 0, rdv_cyc = 0;
  logic [15:0] rdv_data;
  bit          mrs_seen = 0, early_ready = 0;
  logic [15:0] mem[0:1023];
  int          rd_cnt = 0;
  logic [15:0] rd_word;

  function automatic int midx(input logic [1:0] b, input logic [11:0] r,
                              input logic [8:0] c);
    return {b, r[3:0], c[3:0]};
  endfunction

  logic [11:0] open_row[0:3];

  always @(negedge clk) begin
    logic [3:0] c;
    cyc++;
    if (rd_cnt == 1) sd_dq_in = rd_word;
    else             sd_dq_in = 16'hDEAD;
    if (rd_cnt > 0) rd_cnt--;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n && !c[3] && c != 4'b0111 && n_log < 256) begin
      lg_cmd[n_log] = c; lg_cyc[n_log] = cyc; lg_a[n_log] = sd_a;
      lg_ba[n_log] = sd_ba; lg_dq[n_log] = sd_dq_out; lg_oe[n_log] = sd_dq_oe;
      n_log++;
      case (c)
        4'b0011: open_row[sd_ba] = sd_a;
        4'b0100: mem[midx(sd_ba, open_row[sd_ba], sd_a[8:0])] = sd_dq_out;
        4'b0101: begin
          rd_word = mem[midx(sd_ba, open_row[sd_ba], sd_a[8:0])];
          rd_cnt  = CAS_LAT;
        end
        4'b0000: mrs_seen = 1;
        default: ;
      endcase
    end
    if (req_ready && !mrs_seen) early_ready = 1;
    if (rd_valid) begin rdv_n++; rdv_cyc = cyc; rdv_data = rd_data; end
  end

  function automatic int find_cmd(input int from, input logic [3:0] c);
    for (int i = from; i < n_log; i++) if (lg_cmd[i] == c) return i;
    return -1;
  endfunction

  task automatic do_req(input bit w, input logic [1:0] b, input logic [11:0] r,
                        input logic [8:0] c, input logic [15:0] d);
    req_valid = 1; req_write = w; req_bank = b; req_row = r; req_col = c; req_wdata = d;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; req_valid = 0; req_write = 0; req_bank = 0; req_row = 0;
    req_col = 0; req_wdata = 0; sd_dq_in = 0;
    repeat (3) @(negedge clk);
    chk(sd_cs_n == 1'b1, "R1", "cs_n in reset", sd_cs_n, 1);
    rst_n = 1;
    repeat (INIT_CYC / 2) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "nop in wait",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(n_log == 0, "R1", "commands in wait", n_log, 0);
  endtask

  task automatic t_init;
    while (n_log < 4) @(negedge clk);
    chk(lg_cmd[0] == 4'b0010 && lg_a[0][10], "R2", "first precharge-all",
        {lg_cmd[0], lg_a[0]}, {4'b0010, 12'h400});
    chk(lg_cmd[1] == 4'b0001 && lg_cmd[2] == 4'b0001, "R2", "two refreshes",
        {lg_cmd[1], lg_cmd[2]}, 8'h11);
    chk(lg_cmd[3] == 4'b0000 && lg_a[3] == 12'(CAS_LAT << 4) && lg_ba[3] == 0,
        "R2", "mode word", {lg_cmd[3], lg_ba[3], lg_a[3]}, CAS_LAT << 4);
    chk(lg_cyc[1] - lg_cyc[0] == T_RP, "R2", "pre gap", lg_cyc[1] - lg_cyc[0], T_RP);
    chk(lg_cyc[2] - lg_cyc[1] == T_RFC && lg_cyc[3] - lg_cyc[2] == T_RFC, "R2",
        "refresh gaps", lg_cyc[3] - lg_cyc[1], 2 * T_RFC);
    repeat (4) @(negedge clk);
    chk(!early_ready, "R3", "ready before mode load", early_ready, 0);
  endtask

  task automatic t_write(input logic [1:0] b, input logic [11:0] r,
                         input logic [8:0] c, input logic [15:0] d);
    int i0, ia, iw;
    i0 = n_log;
    do_req(1, b, r, c, d);
    req_valid = 0;
    repeat (6) @(negedge clk);
    ia = find_cmd(i0, 4'b0011);
    iw = find_cmd(i0, 4'b0100);
    if (ia < 0 || iw < 0) begin
      chk(0, "R4", "act/write missing", ia, iw);
      return;
    end
    chk(lg_ba[ia] == b && lg_a[ia] == r, "R4", "act bank/row",
        {lg_ba[ia], lg_a[ia]}, {b, r});
    chk(lg_cyc[iw] - lg_cyc[ia] == T_RCD, "R4", "act to write",
        lg_cyc[iw] - lg_cyc[ia], T_RCD);
    chk(lg_a[iw][8:0] == c && lg_a[iw][10] && lg_ba[iw] == b, "R5",
        "write column/ap", lg_a[iw], {3'b010, c});
    chk(lg_oe[iw] && lg_dq[iw] == d, "R5", "write data", {lg_oe[iw], lg_dq[iw]},
        {1'b1, d});
  endtask

  task automatic t_read(input logic [1:0] b, input logic [11:0] r,
                        input logic [8:0] c, input logic [15:0] exp);
    int i0, ir, n0, tmo;
    i0 = n_log; n0 = rdv_n;
    do_req(0, b, r, c, 0);
    req_valid = 0;
    tmo = 0;
    while (rdv_n == n0 && tmo < 40) begin @(negedge clk); tmo++; end
    ir = find_cmd(i0, 4'b0101);
    if (ir < 0 || rdv_n == n0) begin
      chk(0, "R6", "read or strobe missing", ir, rdv_n);
      return;
    end
    chk(lg_a[ir][8:0] == c && lg_a[ir][10] && !lg_oe[ir], "R6", "read column/ap/oe",
        {lg_oe[ir], lg_a[ir]}, {1'b0, 3'b010, c});
    chk(rdv_cyc - lg_cyc[ir] == CAS_LAT + 1, "R6", "read latency",
        rdv_cyc - lg_cyc[ir], CAS_LAT + 1);
    chk(rdv_data == exp, "R6", "read data", rdv_data, exp);
    @(negedge clk);
    chk(rd_valid == 0, "R6", "strobe one cycle", rd_valid, 0);
  endtask

  task automatic t_back_to_back;
    int i0, ia;
    i0 = n_log;
    do_req(1, 2'd1, 12'h00A, 9'h003, 16'h1111);
    do_req(1, 2'd2, 12'h00B, 9'h004, 16'h2222);
    do_req(1, 2'd3, 12'h00C, 9'h005, 16'h3333);
    req_valid = 0;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      ia = find_cmd(i0 + 2 * k + 2, 4'b0011);
      chk(ia >= 1 && lg_cyc[ia] - lg_cyc[ia - 1] == RW_WAIT, "R7",
          "held request spacing", ia >= 1 ? lg_cyc[ia] - lg_cyc[ia - 1] : -1, RW_WAIT);
    end
    t_read(2'd2, 12'h00B, 9'h004, 16'h2222);
  endtask

  task automatic t_ref_idle;
    int i0, prev, nref;
    i0 = n_log; prev = -1; nref = 0;
    repeat (3 * REF_INT + 20) @(negedge clk);
    for (int i = i0; i < n_log; i++) begin
      if (lg_cmd[i] == 4'b0001) begin
        if (prev >= 0)
          chk(lg_cyc[i] - lg_cyc[prev] == REF_INT, "R8", "idle refresh gap",
              lg_cyc[i] - lg_cyc[prev], REF_INT);
        prev = i; nref++;
      end
    end
    chk(nref >= 3, "R8", "idle refresh count", nref, 3);
  endtask

  task automatic t_ref_priority;
    int lr, i0, ir, nact;
    lr = -1;
    for (int i = 0; i < n_log; i++) if (lg_cmd[i] == 4'b0001) lr = lg_cyc[i];
    while (cyc < lr + REF_INT - 4) @(negedge clk);
    i0 = n_log;
    for (int k = 0; k < 8; k++)
      do_req(1, 2'(k), 12'h020, 9'(k), 16'hA000 + 16'(k));
    req_valid = 0;
    repeat (10) @(negedge clk);
    ir = find_cmd(i0, 4'b0001);
    if (ir < 0) begin
      chk(0, "R9", "refresh missing", -1, 0);
      return;
    end
    chk(lg_cyc[ir] - lr >= REF_INT && lg_cyc[ir] - lr <= REF_INT + T_RCD + RW_WAIT,
        "R9", "refresh delay", lg_cyc[ir] - lr, REF_INT);
    chk(ir + 1 < n_log && lg_cmd[ir + 1] == 4'b0011 &&
        lg_cyc[ir + 1] - lg_cyc[ir] == T_RFC, "R9", "command after refresh",
        lg_cyc[ir + 1] - lg_cyc[ir], T_RFC);
    nact = 0;
    for (int i = i0; i < n_log; i++) if (lg_cmd[i] == 4'b0011) nact++;
    chk(nact == 8, "R9", "queued activates", nact, 8);
    t_read(2'd3, 12'h020, 9'd7, 16'hA007);
  endtask

  initial begin
    t_reset;
    t_init;
    t_write(2'd0, 12'h005, 9'h001, 16'hBEEF);          // R10 encodings used throughout
    t_read(2'd0, 12'h005, 9'h001, 16'hBEEF);
    t_write(2'd3, 12'hFFF, 9'h1FF, 16'h5A5A);
    t_read(2'd3, 12'hFFF, 9'h1FF, 16'h5A5A);
    t_back_to_back;
    t_ref_idle;
    t_ref_priority;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule